// File: doc/BRIEF.md
# Multi-Domain Reset Controller

This block merges reset requests from many sources into separate active-low reset outputs for the power domain, the debug port, the core and peripherals (system reset) and the backup domain. A power-on/power-down detect or a standby exit raises power reset, and power reset stays asserted until the regulator reports ready. System reset is raised by power reset, the external reset pin, either watchdog, a software request, an option-loader reload, or a low-power entry whose option bit permits it. Every system reset is stretched by a counter to a minimum low time. The debug-port reset follows power reset only. The backup-domain reset answers only its own request.

Sticky cause flags record which source triggered a reset. Software reads the flags and clears them with a strobe. Power reset leaves only the power flag set. The minimum pulse length is set by two parameters: the clock rate in cycles per microsecond, and the minimum width in microseconds.

Top module: `rst_domain_ctrl`

## Requirements
- R1: Power reset (`pwr_rst_n` low) asserts at once while `por_det` is high, and asserts at the clock edge that samples `stby_exit` high.
- R2: Once asserted, power reset stays low until an edge samples `ldo_ready` high with `stby_exit` low; it is released at that edge.
- R3: `dbg_rst_n` follows power reset only and stays high during system resets from any other source.
- R4: System reset (`sys_rst_n` low) asserts at the edge after which power reset is active, and at the edge that samples any of `wwdg_req`, `fwdg_req`, `sw_req`, `optld_req` high.
- R5: `ext_rst_n` passes through two synchronizer flops; a low pin level first drives `sys_rst_n` low after the third edge that follows the pin falling.
- R6: `stby_entry` causes a system reset only when `opt_stby_noreset` is 0, and `dslp_entry` only when `opt_dslp_noreset` is 0; with the option bit at 1 the entry event has no effect on `sys_rst_n` or on the flags.
- R7: After the last edge that samples a request, `sys_rst_n` stays low for exactly MIN_US*CYC_PER_US cycles (2000 by default). A new request during a pulse restarts the full length.
- R8: `bkp_rst_n` asserts at once while `bkp_req` is high and is released at the second edge after `bkp_req` falls. Power reset and system reset have no effect on it.
- R9: `cause_flags` bit positions: 0 power, 1 pin, 2 window watchdog, 3 free watchdog, 4 software, 5 option loader, 6 standby entry, 7 deep-sleep entry. A bit sets at the edge where its request is sampled; during power reset the flags read 8'h01.
- R10: A high `flags_clr` clears all flags at the next edge. A request sampled at that same edge still sets its own bit.
- R11: Flags are sticky. A system reset does not clear them; only power reset or `flags_clr` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| por_det | input | 1 | Power-on/power-down detect, high = fault, asynchronous |
| ldo_ready | input | 1 | Regulator output ready |
| stby_exit | input | 1 | Standby-exit event |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wwdg_req | input | 1 | Window watchdog reset request |
| fwdg_req | input | 1 | Free watchdog reset request |
| sw_req | input | 1 | Software reset request |
| optld_req | input | 1 | Option-loader reload request |
| stby_entry | input | 1 | Standby-entry event |
| dslp_entry | input | 1 | Deep-sleep-entry event |
| opt_stby_noreset | input | 1 | Option bit: 0 = standby entry resets |
| opt_dslp_noreset | input | 1 | Option bit: 0 = deep-sleep entry resets |
| bkp_req | input | 1 | Backup-domain reset request, asynchronous |
| flags_clr | input | 1 | Clear strobe for the cause flags |
| pwr_rst_n | output | 1 | Power reset, active low |
| dbg_rst_n | output | 1 | Debug-port reset, active low |
| sys_rst_n | output | 1 | System reset for core and peripherals, active low |
| bkp_rst_n | output | 1 | Backup-domain reset, active low |
| cause_flags | output | 8 | Sticky reset-cause flags |

## Verification
A synchronous request moves `sys_rst_n` and its cause flag one edge after it is sampled. The pin needs three edges. Power reset answers `stby_exit` and `ldo_ready` at the sampling edge, and the backup reset releases two edges after its request falls. The reference model in the bench advances on the rising edge with the same register counts, and all outputs are compared a few nanoseconds later on every cycle. Directed checks drive stimuli on falling edges and read results at the falling edges that follow. Pulse widths are measured by counting falling-edge samples in which `sys_rst_n` is low.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam int unsigned N_CAUSE = 8;

  typedef enum int unsigned {
    C_PWR  = 0,
    C_PIN  = 1,
    C_WWDG = 2,
    C_FWDG = 3,
    C_SW   = 4,
    C_OPTL = 5,
    C_STBY = 6,
    C_DSLP = 7
  } cause_e;

  typedef logic [N_CAUSE-1:0] cause_vec_t;
endpackage

// File: rtl/rstc_sync.sv
module rstc_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sh_q <= {STAGES{RST_VAL}};
    end else begin
      sh_q <= sh_d;
    end
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/rstc_pwr.sv
module rstc_pwr (
  input  logic clk,
  input  logic arst_n,
  input  logic stby_exit,
  input  logic ldo_ready,
  output logic active
);
  logic act_d;

  always_comb begin
    if (stby_exit) begin
      act_d = 1'b1;
    end else if (ldo_ready) begin
      act_d = 1'b0;
    end else begin
      act_d = active;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      active <= 1'b1;
    end else begin
      active <= act_d;
    end
  end

  // R2: held while the regulator is not ready
  p_hold_r2: assert property (@(posedge clk) disable iff (!arst_n)
    (active && !ldo_ready) |=> active);

  // R1: standby exit raises power reset
  p_exit_r1: assert property (@(posedge clk) disable iff (!arst_n)
    stby_exit |=> active);
endmodule

// File: rtl/rstc_stretch.sv
module rstc_stretch #(
  parameter int unsigned PULSE = 2000
) (
  input  logic clk,
  input  logic arst_n,
  input  logic req,
  output logic low
);
  localparam int unsigned CW = $clog2(PULSE + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;
  logic          low_d;

  always_comb begin
    cnt_en = req | (cnt_q != '0);
    cnt_d  = cnt_q;
    if (req) begin
      cnt_d = LOAD;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
    low_d = (cnt_d != '0);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q <= LOAD;
      low   <= 1'b1;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      low   <= low_d;
    end
  end

  // checker: length of the current low run, saturating at PULSE
  logic [CW-1:0] run_q;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      run_q <= '0;
    end else if (!low) begin
      run_q <= '0;
    end else if (run_q != LOAD) begin
      run_q <= run_q + 1'b1;
    end
  end

  // R4: a sampled request drives the reset low at the next edge
  p_load_r4: assert property (@(posedge clk) disable iff (!arst_n)
    req |=> low);

  // R7: no release before the minimum width has elapsed
  p_min_width_r7: assert property (@(posedge clk) disable iff (!arst_n)
    (!low && $past(low)) |-> (run_q == LOAD));
endmodule

// File: rtl/rstc_cause.sv
module rstc_cause
  import rstc_pkg::*;
(
  input  logic       clk,
  input  logic       arst_n,
  input  logic       pwr_active,
  input  logic       clr,
  input  cause_vec_t set_vec,
  output cause_vec_t flags
);
  for (genvar g = 0; g < N_CAUSE; g++) begin : g_flag
    localparam logic PWR_BIT = (g == C_PWR);
    logic q;
    logic d;

    always_comb begin
      if (pwr_active) begin
        d = PWR_BIT;
      end else begin
        d = (q & ~clr) | set_vec[g];
      end
    end

    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
        q <= PWR_BIT;
      end else begin
        q <= d;
      end
    end

    assign flags[g] = q;
  end

  // R9: during power reset only the power flag is reported
  p_pwr_only_r9: assert property (@(posedge clk) disable iff (!arst_n)
    pwr_active |=> (flags == cause_vec_t'(1)));

  // R10: clear with nothing pending empties the flags
  p_clear_r10: assert property (@(posedge clk) disable iff (!arst_n)
    (clr && !pwr_active && set_vec == '0) |=> (flags == '0));

  // R11: without clear or power reset, no flag drops
  p_sticky_r11: assert property (@(posedge clk) disable iff (!arst_n)
    (!clr && !pwr_active) |=> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: rtl/rst_domain_ctrl.sv
module rst_domain_ctrl
  import rstc_pkg::*;
#(
  parameter int unsigned CYC_PER_US = 100,
  parameter int unsigned MIN_US     = 20
) (
  input  logic       clk,
  input  logic       por_det,
  input  logic       ldo_ready,
  input  logic       stby_exit,
  input  logic       ext_rst_n,
  input  logic       wwdg_req,
  input  logic       fwdg_req,
  input  logic       sw_req,
  input  logic       optld_req,
  input  logic       stby_entry,
  input  logic       dslp_entry,
  input  logic       opt_stby_noreset,
  input  logic       opt_dslp_noreset,
  input  logic       bkp_req,
  input  logic       flags_clr,
  output logic       pwr_rst_n,
  output logic       dbg_rst_n,
  output logic       sys_rst_n,
  output logic       bkp_rst_n,
  output logic [7:0] cause_flags
);
  localparam int unsigned PULSE = CYC_PER_US * MIN_US;

  logic       arst_n;
  logic       bkp_arst_n;
  logic       pin_s;
  logic       pwr_active;
  logic       sys_low;
  logic       any_req;
  logic       bkp_rel;
  cause_vec_t set_vec;
  cause_vec_t flags;

  assign arst_n     = ~por_det;
  assign bkp_arst_n = ~bkp_req;

  rstc_sync #(.STAGES(2), .RST_VAL(1'b1)) u_pin_sync (
    .clk    (clk),
    .arst_n (arst_n),
    .d      (ext_rst_n),
    .q      (pin_s)
  );

  rstc_pwr u_pwr (
    .clk       (clk),
    .arst_n    (arst_n),
    .stby_exit (stby_exit),
    .ldo_ready (ldo_ready),
    .active    (pwr_active)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[C_PWR]  = pwr_active;
    set_vec[C_PIN]  = ~pin_s;
    set_vec[C_WWDG] = wwdg_req;
    set_vec[C_FWDG] = fwdg_req;
    set_vec[C_SW]   = sw_req;
    set_vec[C_OPTL] = optld_req;
    set_vec[C_STBY] = stby_entry & ~opt_stby_noreset;
    set_vec[C_DSLP] = dslp_entry & ~opt_dslp_noreset;
    any_req         = |set_vec;
  end

  rstc_stretch #(.PULSE(PULSE)) u_stretch (
    .clk    (clk),
    .arst_n (arst_n),
    .req    (any_req),
    .low    (sys_low)
  );

  rstc_cause u_cause (
    .clk        (clk),
    .arst_n     (arst_n),
    .pwr_active (pwr_active),
    .clr        (flags_clr),
    .set_vec    (set_vec),
    .flags      (flags)
  );

  // backup domain: its own asynchronous reset, synchronous release
  rstc_sync #(.STAGES(2), .RST_VAL(1'b0)) u_bkp_sync (
    .clk    (clk),
    .arst_n (bkp_arst_n),
    .d      (1'b1),
    .q      (bkp_rel)
  );

  assign pwr_rst_n   = ~pwr_active;
  assign dbg_rst_n   = ~pwr_active;
  assign sys_rst_n   = ~sys_low;
  assign bkp_rst_n   = bkp_rel;
  assign cause_flags = flags;

  // R5: synchronized pin low reaches the system reset one edge later
  p_pin_r5: assert property (@(posedge clk) disable iff (!arst_n)
    !pin_s |=> !sys_rst_n);

  // R6: enabled standby entry resets the system
  p_stby_r6: assert property (@(posedge clk) disable iff (!arst_n)
    (stby_entry && !opt_stby_noreset) |=> !sys_rst_n);

  // R4: power reset implies system reset one edge later
  p_pwr_sys_r4: assert property (@(posedge clk) disable iff (!arst_n)
    !pwr_rst_n |=> !sys_rst_n);
endmodule

// File: tb/sim_rst_domain_ctrl.sv
module sim_rst_domain_ctrl;
  localparam int CPU = 100;
  localparam int MUS = 20;
  localparam int P   = CPU * MUS;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic por_det = 1'b1, ldo_ready = 1'b0, stby_exit = 1'b0, ext_rst_n = 1'b1;
  logic wwdg_req = 1'b0, fwdg_req = 1'b0, sw_req = 1'b0, optld_req = 1'b0;
  logic stby_entry = 1'b0, dslp_entry = 1'b0;
  logic opt_stby_noreset = 1'b1, opt_dslp_noreset = 1'b1;
  logic bkp_req = 1'b1, flags_clr = 1'b0;
  logic pwr_rst_n, dbg_rst_n, sys_rst_n, bkp_rst_n;
  logic [7:0] cause_flags;

  rst_domain_ctrl #(.CYC_PER_US(CPU), .MIN_US(MUS)) u0 (
    .clk(clk), .por_det(por_det), .ldo_ready(ldo_ready), .stby_exit(stby_exit),
    .ext_rst_n(ext_rst_n), .wwdg_req(wwdg_req), .fwdg_req(fwdg_req),
    .sw_req(sw_req), .optld_req(optld_req), .stby_entry(stby_entry),
    .dslp_entry(dslp_entry), .opt_stby_noreset(opt_stby_noreset),
    .opt_dslp_noreset(opt_dslp_noreset), .bkp_req(bkp_req),
    .flags_clr(flags_clr), .pwr_rst_n(pwr_rst_n), .dbg_rst_n(dbg_rst_n),
    .sys_rst_n(sys_rst_n), .bkp_rst_n(bkp_rst_n), .cause_flags(cause_flags)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  bit       m_pwr = 1'b1, m_p1 = 1'b1, m_p2 = 1'b1, m_b1 = 1'b0, m_b2 = 1'b0;
  int       m_cnt = P;
  bit [7:0] m_flags = 8'h01;
  bit       m_live = 1'b0;

  always @(posedge clk) begin
    bit [7:0] src;
    if (por_det) begin
      m_pwr = 1'b1; m_cnt = P; m_p1 = 1'b1; m_p2 = 1'b1; m_flags = 8'h01;
    end else begin
      src = '0;
      src[0] = m_pwr;
      src[1] = !m_p2;
      src[2] = wwdg_req;
      src[3] = fwdg_req;
      src[4] = sw_req;
      src[5] = optld_req;
      src[6] = stby_entry && !opt_stby_noreset;
      src[7] = dslp_entry && !opt_dslp_noreset;
      if (m_pwr) m_flags = 8'h01;
      else m_flags = (flags_clr ? 8'h00 : m_flags) | src;
      if (src != 0) m_cnt = P;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      m_pwr = stby_exit ? 1'b1 : (ldo_ready ? 1'b0 : m_pwr);
      m_p2 = m_p1;
      m_p1 = ext_rst_n;
    end
    if (bkp_req) begin
      m_b1 = 1'b0; m_b2 = 1'b0;
    end else begin
      m_b2 = m_b1; m_b1 = 1'b1;
    end
    m_live = 1'b1;
  end

  always @(posedge clk) begin
    #3;
    if (m_live) begin
      chk(pwr_rst_n == !m_pwr, "R1/R2 pwr_rst_n per cycle", pwr_rst_n, !m_pwr);
      chk(dbg_rst_n == !m_pwr, "R3 dbg_rst_n per cycle", dbg_rst_n, !m_pwr);
      chk(sys_rst_n == (m_cnt == 0), "R4-R7 sys_rst_n per cycle", sys_rst_n, (m_cnt == 0));
      chk(bkp_rst_n == m_b2, "R8 bkp_rst_n per cycle", bkp_rst_n, m_b2);
      chk(cause_flags == m_flags, "R9-R11 flags per cycle", cause_flags, m_flags);
    end
  end

  task automatic fire(input int idx);
    @(negedge clk);
    case (idx)
      2: wwdg_req = 1'b1;
      3: fwdg_req = 1'b1;
      4: sw_req = 1'b1;
      5: optld_req = 1'b1;
      default: ;
    endcase
    @(negedge clk);
    wwdg_req = 1'b0; fwdg_req = 1'b0; sw_req = 1'b0; optld_req = 1'b0;
  endtask

  task automatic measure_low(output int n);
    n = 0;
    while (sys_rst_n == 1'b0 && n < 3 * P) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic clear_flags;
    @(negedge clk); flags_clr = 1'b1;
    @(negedge clk); flags_clr = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    repeat (4) @(negedge clk);
    chk(pwr_rst_n == 1'b0, "R1 reset state pwr", pwr_rst_n, 0);
    chk(sys_rst_n == 1'b0, "R4 reset state sys", sys_rst_n, 0);
    chk(dbg_rst_n == 1'b0, "R3 reset state dbg", dbg_rst_n, 0);
    chk(bkp_rst_n == 1'b0, "R8 reset state bkp", bkp_rst_n, 0);
    chk(cause_flags == 8'h01, "R9 reset state flags", cause_flags, 8'h01);

    bkp_req = 1'b0;
    @(negedge clk);
    chk(bkp_rst_n == 1'b0, "R8 bkp held one edge", bkp_rst_n, 0);
    @(negedge clk);
    chk(bkp_rst_n == 1'b1, "R8 bkp released second edge", bkp_rst_n, 1);

    por_det = 1'b0;
    repeat (5) @(negedge clk);
    chk(pwr_rst_n == 1'b0, "R2 held without ldo_ready", pwr_rst_n, 0);
    ldo_ready = 1'b1;
    @(negedge clk);
    chk(pwr_rst_n == 1'b1, "R2 released on ldo_ready", pwr_rst_n, 1);
    measure_low(n);
    chk(n == P, "R7 width after power reset", n, P);
    chk(cause_flags == 8'h01, "R11 power flag kept", cause_flags, 8'h01);
    clear_flags();
    chk(cause_flags == 8'h00, "R10 clear strobe", cause_flags, 0);

    for (int i = 2; i <= 5; i++) begin
      fire(i);
      chk(sys_rst_n == 1'b0, "R4 source asserts sys", sys_rst_n, 0);
      chk(dbg_rst_n == 1'b1, "R3 dbg unaffected", dbg_rst_n, 1);
      measure_low(n);
      chk(n == P, "R7 pulse width", n, P);
      chk(cause_flags == (8'h01 << i), "R9 flag position, R11 kept", cause_flags, 8'h01 << i);
      clear_flags();
    end

    fire(4);
    clear_flags();
    @(negedge clk); flags_clr = 1'b1; wwdg_req = 1'b1;
    @(negedge clk); flags_clr = 1'b0; wwdg_req = 1'b0;
    chk(cause_flags == 8'h04, "R10 set wins over clear", cause_flags, 8'h04);
    measure_low(n);
    clear_flags();

    fire(4);
    repeat (1000) @(negedge clk);
    fire(4);
    measure_low(n);
    chk(n == P, "R7 restart on new request", n, P);
    clear_flags();

    @(negedge clk); ext_rst_n = 1'b0;
    @(negedge clk);
    chk(sys_rst_n == 1'b1, "R5 sync edge 1", sys_rst_n, 1);
    @(negedge clk);
    chk(sys_rst_n == 1'b1, "R5 sync edge 2", sys_rst_n, 1);
    @(negedge clk);
    chk(sys_rst_n == 1'b0, "R5 asserted edge 3", sys_rst_n, 0);
    ext_rst_n = 1'b1;
    chk(cause_flags == 8'h02, "R9 pin flag", cause_flags, 8'h02);
    measure_low(n);
    clear_flags();

    @(negedge clk); stby_entry = 1'b1;
    @(negedge clk); stby_entry = 1'b0; dslp_entry = 1'b1;
    @(negedge clk); dslp_entry = 1'b0;
    repeat (2) @(negedge clk);
    chk(sys_rst_n == 1'b1, "R6 entries ignored with option 1", sys_rst_n, 1);
    chk(cause_flags == 8'h00, "R6 no flag with option 1", cause_flags, 0);

    opt_stby_noreset = 1'b0;
    @(negedge clk); stby_entry = 1'b1;
    @(negedge clk); stby_entry = 1'b0;
    chk(sys_rst_n == 1'b0, "R6 standby entry resets", sys_rst_n, 0);
    chk(cause_flags == 8'h40, "R6 standby flag", cause_flags, 8'h40);
    measure_low(n);
    clear_flags();
    opt_dslp_noreset = 1'b0;
    @(negedge clk); dslp_entry = 1'b1;
    @(negedge clk); dslp_entry = 1'b0;
    chk(sys_rst_n == 1'b0, "R6 deep-sleep entry resets", sys_rst_n, 0);
    chk(cause_flags == 8'h80, "R6 deep-sleep flag", cause_flags, 8'h80);
    measure_low(n);

    @(negedge clk); stby_exit = 1'b1;
    @(negedge clk); stby_exit = 1'b0;
    chk(pwr_rst_n == 1'b0, "R1 standby exit asserts", pwr_rst_n, 0);
    chk(dbg_rst_n == 1'b0, "R3 dbg follows power", dbg_rst_n, 0);
    @(negedge clk);
    chk(pwr_rst_n == 1'b1, "R2 release with ldo_ready", pwr_rst_n, 1);
    chk(cause_flags == 8'h01, "R9 power flag only", cause_flags, 8'h01);
    measure_low(n);

    @(negedge clk); por_det = 1'b1;
    @(negedge clk);
    chk(pwr_rst_n == 1'b0, "R1 por asserts", pwr_rst_n, 0);
    chk(bkp_rst_n == 1'b1, "R8 bkp ignores power reset", bkp_rst_n, 1);
    por_det = 1'b0;
    repeat (2) @(negedge clk);
    @(negedge clk); bkp_req = 1'b1;
    @(negedge clk); bkp_req = 1'b0;
    chk(sys_rst_n == 1'b0, "R8 sys pulse independent", sys_rst_n, 0);
    measure_low(n);
    chk(bkp_rst_n == 1'b1, "R8 bkp released", bkp_rst_n, 1);

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule